// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM command bus. After reset it holds clock-enable low while the supply and clock settle. It then raises clock-enable and walks the device through its mandatory start-up order:

- a precharge of all banks;
- an extended mode write that turns the delay-locked loop on;
- a mode write that resets that loop;
- a second all-bank precharge;
- a programmable number of auto-refreshes;
- a final mode write with the loop-reset bit cleared.

Waits between commands are counted in clocks. The settle time is derived from a clock-frequency parameter. The spacing after precharge, mode writes and refresh comes from cycle-count parameters.

Burst length, burst type, read latency and output drive strength come from configuration inputs and are encoded into the mode words at the moment each write is issued. Every cycle that does not carry a sequence command drives a no-operation. A done flag rises only after two conditions have both been met: the last mode-write spacing has passed, and the loop has had its lock time since its reset. After that, the normal controller may take over the bus.

Top module: `ddrPowerUpSeq`

## Requirements
- R1: While reset is asserted, and for STABLE_US*CLK_MHZ clocks after it is released, cke is 0, the pins {csN,rasN,casN,weN} carry the no-op code 4'b0111, addr and ba are 0, and initDone and cfgError are 0.
- R2: When the settle time has elapsed, cke goes to 1 with a no-op for one clock. The next clock carries precharge-all: pins 4'b0010, addr bit 10 set, all other addr bits 0, ba 0.
- R3: The commands appear in a fixed order: precharge-all, then extended mode write, then mode write with loop reset, then precharge-all, then NUM_REFRESH refreshes (pins 4'b0001, addr 0, ba 0), then the final mode write.
- R4: Spacing between commands is fixed. The next command follows a precharge-all T_RP clocks later, follows a mode write T_MRD clocks later, and follows each refresh T_RFC clocks later. Every clock in between carries a no-op with addr 0 and ba 0.
- R5: The extended mode write uses pins 4'b0000 and ba 2'b01. Its addr has bit 0 = 0, bit 1 = driveSel[0] and bit 6 = driveSel[1]; all other addr bits are 0.
- R6: Mode writes use pins 4'b0000 and ba 2'b00. In addr, bits 2:0 = burstLen, bit 3 = burstType, bits 6:4 = the read latency as a binary number, bit 7 = 0 and bits 10:9 = 0. Bit 8 is 1 in the first mode write and 0 in the final one.
- R7: initDone rises exactly max(F+T_MRD, M+DLL_LOCK_CLKS) clocks after reset release. Here F is the clock of the final mode write and M is the clock of the loop-reset mode write, both counted from reset release. From then on, initDone stays 1 and the bus carries only no-ops with cke 1, whatever the configuration inputs do.
- R8: A casLat value outside 3..5 is encoded as 3 in the mode words. cfgError is 1 exactly one clock after such a value is present and 0 one clock after a legal value.
- R9: Once cke has risen, it stays 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| casLat | input | 3 | Requested read latency in clocks (3..5 legal) |
| burstLen | input | 3 | Burst length code placed in addr bits 2:0 |
| burstType | input | 1 | 0 sequential, 1 interleaved |
| driveSel | input | 2 | Output drive strength code, bit 0 to addr 1, bit 1 to addr 6 |
| cke | output | 1 | Clock enable to the memory |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus |
| ba | output | 2 | Bank address |
| initDone | output | 1 | Initialization complete |
| cfgError | output | 1 | Illegal latency request seen last clock |

## Verification
The bench builds two instances with a reduced clock-frequency parameter so that the settle phase lasts tens of clocks instead of tens of thousands.

The first instance keeps the full 200-clock lock time with three refreshes, so the lock counter decides when done rises. The second has a lock time of 10, gaps of 2 and 3, and two refreshes, so the spacing after the final mode write decides instead.

Between them, and across two reset passes, the instances see legal and illegal latency requests, both burst types and several drive codes. The bench also changes configuration after done, which shows the inputs no longer reach the bus and that the error flag follows its input.

// File: rtl/initSeqPkg.sv
`timescale 1ns/1ps
package initSeqPkg;

  // Step the control asks the pin stage to present on the next clock.
  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_PREA,
    CMD_EMRS,
    CMD_MRS_DLLRST,
    CMD_MRS_FINAL,
    CMD_REF
  } seqCmd_e;

  typedef struct packed {
    logic    ckeOn;
    seqCmd_e cmd;
    logic    done;
  } seqStrobe_t;

  // {csN, rasN, casN, weN}
  localparam logic [3:0] PINS_NOP  = 4'b0111;
  localparam logic [3:0] PINS_PRE  = 4'b0010;
  localparam logic [3:0] PINS_REF  = 4'b0001;
  localparam logic [3:0] PINS_MODE = 4'b0000;

endpackage

// File: rtl/initSeqCtrl.sv
`timescale 1ns/1ps
module initSeqCtrl
  import initSeqPkg::*;
#(
  parameter int STABLE_CLKS   = 40000,
  parameter int T_RP          = 3,
  parameter int T_MRD         = 2,
  parameter int T_RFC         = 12,
  parameter int DLL_LOCK_CLKS = 200,
  parameter int NUM_REFRESH   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  output seqStrobe_t strobe
);

  localparam int WAIT_W = $clog2(STABLE_CLKS + T_RP + T_MRD + T_RFC + 1);
  localparam int LOCK_W = $clog2(DLL_LOCK_CLKS + 1);
  localparam int REF_W  = $clog2(NUM_REFRESH + 1);

  typedef enum logic [3:0] {
    ST_STABLE, ST_CKE, ST_PREA1, ST_EMRS, ST_MRSRST, ST_PREA2,
    ST_REF, ST_MRSFIN, ST_GAP, ST_FINWAIT, ST_DONE
  } seqState_e;

  seqState_e         state, stateNxt, resume, resumeNxt;
  logic [WAIT_W-1:0] waitCnt, waitNxt;
  logic [LOCK_W-1:0] lockCnt;
  logic [REF_W-1:0]  refLeft, refNxt;

  always_comb begin
    stateNxt  = state;
    resumeNxt = resume;
    waitNxt   = waitCnt;
    refNxt    = refLeft;
    unique case (state)
      ST_STABLE: begin
        if (waitCnt == '0) stateNxt = ST_CKE;
        else               waitNxt  = waitCnt - 1'b1;
      end
      ST_CKE:   stateNxt = ST_PREA1;
      ST_PREA1: begin
        waitNxt = WAIT_W'(T_RP - 2); resumeNxt = ST_EMRS; stateNxt = ST_GAP;
      end
      ST_EMRS: begin
        waitNxt = WAIT_W'(T_MRD - 2); resumeNxt = ST_MRSRST; stateNxt = ST_GAP;
      end
      ST_MRSRST: begin
        waitNxt = WAIT_W'(T_MRD - 2); resumeNxt = ST_PREA2; stateNxt = ST_GAP;
      end
      ST_PREA2: begin
        waitNxt = WAIT_W'(T_RP - 2); resumeNxt = ST_REF; stateNxt = ST_GAP;
        refNxt  = REF_W'(NUM_REFRESH);
      end
      ST_REF: begin
        waitNxt   = WAIT_W'(T_RFC - 2);
        refNxt    = refLeft - 1'b1;
        resumeNxt = (refLeft == REF_W'(1)) ? ST_MRSFIN : ST_REF;
        stateNxt  = ST_GAP;
      end
      ST_MRSFIN: begin
        waitNxt = WAIT_W'(T_MRD - 2); stateNxt = ST_FINWAIT;
      end
      ST_GAP: begin
        if (waitCnt == '0) stateNxt = resume;
        else               waitNxt  = waitCnt - 1'b1;
      end
      ST_FINWAIT: begin
        if (waitCnt == '0 && lockCnt == '0) stateNxt = ST_DONE;
        else if (waitCnt != '0)             waitNxt  = waitCnt - 1'b1;
      end
      default: stateNxt = ST_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_STABLE;
      resume  <= ST_STABLE;
      waitCnt <= WAIT_W'(STABLE_CLKS - 1);
      refLeft <= '0;
    end else begin
      state   <= stateNxt;
      resume  <= resumeNxt;
      waitCnt <= waitNxt;
      refLeft <= refNxt;
    end
  end

  // Lock time runs in parallel with the rest of the sequence.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   lockCnt <= '0;
    else if (state == ST_MRSRST) lockCnt <= LOCK_W'(DLL_LOCK_CLKS - 2);
    else if (lockCnt != '0)      lockCnt <= lockCnt - 1'b1;
  end

  always_comb begin
    strobe.ckeOn = (state != ST_STABLE);
    strobe.done  = (state == ST_DONE);
    unique case (state)
      ST_PREA1, ST_PREA2: strobe.cmd = CMD_PREA;
      ST_EMRS:            strobe.cmd = CMD_EMRS;
      ST_MRSRST:          strobe.cmd = CMD_MRS_DLLRST;
      ST_MRSFIN:          strobe.cmd = CMD_MRS_FINAL;
      ST_REF:             strobe.cmd = CMD_REF;
      default:            strobe.cmd = CMD_NOP;
    endcase
  end

  AST_DONE_TERMINAL: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_DONE |=> state == ST_DONE); // R7
  AST_LOCK_SPENT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.done) |-> lockCnt == '0); // R7
  AST_ALL_REFRESHED: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_MRSFIN |-> refLeft == '0); // R3

endmodule

// File: rtl/initSeqPath.sv
`timescale 1ns/1ps
module initSeqPath
  import initSeqPkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [2:0]        casLat,
  input  logic [2:0]        burstLen,
  input  logic              burstType,
  input  logic [1:0]        driveSel,
  output logic              cke,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [ADDR_W-1:0] addr,
  output logic [1:0]        ba,
  output logic              initDone,
  output logic              cfgError
);

  localparam int AP_BIT     = 10;
  localparam int DLLRST_BIT = 8;

  logic              clOk;
  logic [2:0]        clUsed;
  logic [ADDR_W-1:0] modeWord, extWord, addrNxt;
  logic [3:0]        pinsNxt;
  logic [1:0]        baNxt;

  always_comb begin
    clOk   = (casLat inside {3'd3, 3'd4, 3'd5});
    clUsed = clOk ? casLat : 3'd3;

    modeWord        = '0;
    modeWord[2:0]   = burstLen;
    modeWord[3]     = burstType;
    modeWord[6:4]   = clUsed;

    extWord         = '0;
    extWord[1]      = driveSel[0];
    extWord[6]      = driveSel[1];
  end

  always_comb begin
    pinsNxt = PINS_NOP;
    addrNxt = '0;
    baNxt   = 2'b00;
    unique case (strobe.cmd)
      CMD_PREA: begin
        pinsNxt         = PINS_PRE;
        addrNxt[AP_BIT] = 1'b1;
      end
      CMD_EMRS: begin
        pinsNxt = PINS_MODE;
        addrNxt = extWord;
        baNxt   = 2'b01;
      end
      CMD_MRS_DLLRST: begin
        pinsNxt             = PINS_MODE;
        addrNxt             = modeWord;
        addrNxt[DLLRST_BIT] = 1'b1;
      end
      CMD_MRS_FINAL: begin
        pinsNxt = PINS_MODE;
        addrNxt = modeWord;
      end
      CMD_REF: pinsNxt = PINS_REF;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cke                    <= 1'b0;
      {csN, rasN, casN, weN} <= PINS_NOP;
      addr                   <= '0;
      ba                     <= 2'b00;
      initDone               <= 1'b0;
      cfgError               <= 1'b0;
    end else begin
      cke                    <= strobe.ckeOn;
      {csN, rasN, casN, weN} <= pinsNxt;
      addr                   <= addrNxt;
      ba                     <= baNxt;
      initDone               <= strobe.done;
      cfgError               <= !clOk;
    end
  end

  AST_CKE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    cke |=> cke); // R9
  AST_QUIET_CKE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !cke |-> ({csN, rasN, casN, weN} == PINS_NOP && addr == '0)); // R1
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone); // R7
  AST_DONE_IDLE_BUS: assert property (@(posedge clk) disable iff (!rstN)
    initDone |-> ({csN, rasN, casN, weN} == PINS_NOP && cke)); // R7
  AST_MODE_GAP: assert property (@(posedge clk) disable iff (!rstN)
    ($past({csN, rasN, casN, weN}) == PINS_MODE) |-> ({csN, rasN, casN, weN} == PINS_NOP)); // R4
  AST_CL_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    ({csN, rasN, casN, weN} == PINS_MODE && ba == 2'b00) |-> (addr[6:4] inside {3'd3, 3'd4, 3'd5})); // R8
  AST_EXT_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    ({csN, rasN, casN, weN} == PINS_MODE && ba == 2'b01) |-> ((addr & ~ADDR_W'(7'b1000010)) == '0)); // R5

endmodule

// File: rtl/ddrPowerUpSeq.sv
`timescale 1ns/1ps
module ddrPowerUpSeq
  import initSeqPkg::*;
#(
  parameter int CLK_MHZ       = 200,
  parameter int STABLE_US     = 200,
  parameter int T_RP          = 3,
  parameter int T_MRD         = 2,
  parameter int T_RFC         = 12,
  parameter int DLL_LOCK_CLKS = 200,
  parameter int NUM_REFRESH   = 2,
  parameter int ADDR_W        = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        casLat,
  input  logic [2:0]        burstLen,
  input  logic              burstType,
  input  logic [1:0]        driveSel,
  output logic              cke,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [ADDR_W-1:0] addr,
  output logic [1:0]        ba,
  output logic              initDone,
  output logic              cfgError
);

  localparam int STABLE_CLKS = CLK_MHZ * STABLE_US;

  seqStrobe_t strobe;

  initSeqCtrl #(
    .STABLE_CLKS   (STABLE_CLKS),
    .T_RP          (T_RP),
    .T_MRD         (T_MRD),
    .T_RFC         (T_RFC),
    .DLL_LOCK_CLKS (DLL_LOCK_CLKS),
    .NUM_REFRESH   (NUM_REFRESH)
  ) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe)
  );

  initSeqPath #(
    .ADDR_W (ADDR_W)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .casLat    (casLat),
    .burstLen  (burstLen),
    .burstType (burstType),
    .driveSel  (driveSel),
    .cke       (cke),
    .csN       (csN),
    .rasN      (rasN),
    .casN      (casN),
    .weN       (weN),
    .addr      (addr),
    .ba        (ba),
    .initDone  (initDone),
    .cfgError  (cfgError)
  );

endmodule

// File: tb/tb_ddrPowerUpSeq.sv
`timescale 1ns/1ps
module tb_ddrPowerUpSeq;

  typedef struct {
    bit        cke;
    bit [3:0]  pins;
    bit [10:0] addr;
    bit [1:0]  ba;
    bit        done;
    string     req;
  } expEnt_t;
  typedef expEnt_t expQ_t[$];

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  int tests = 0;
  int fails = 0;

  // instance A: lock time decides done
  logic [2:0] clA = 3'd5, blA = 3'd3;
  logic btA = 1'b1;
  logic [1:0] drA = 2'b11;
  logic ckeA, csA, rasA, casA, weA, doneA, errA;
  logic [10:0] addrA;
  logic [1:0] baA;

  // instance B: final mode gap decides done
  logic [2:0] clB = 3'd7, blB = 3'd1;
  logic btB = 1'b0;
  logic [1:0] drB = 2'b01;
  logic ckeB, csB, rasB, casB, weB, doneB, errB;
  logic [10:0] addrB;
  logic [1:0] baB;

  ddrPowerUpSeq #(.CLK_MHZ(4), .STABLE_US(5), .T_RP(3), .T_MRD(2), .T_RFC(5),
                  .DLL_LOCK_CLKS(200), .NUM_REFRESH(3), .ADDR_W(11)) dut (
    .clk(clk), .rstN(rstN), .casLat(clA), .burstLen(blA), .burstType(btA), .driveSel(drA),
    .cke(ckeA), .csN(csA), .rasN(rasA), .casN(casA), .weN(weA), .addr(addrA), .ba(baA),
    .initDone(doneA), .cfgError(errA));

  ddrPowerUpSeq #(.CLK_MHZ(2), .STABLE_US(4), .T_RP(2), .T_MRD(3), .T_RFC(4),
                  .DLL_LOCK_CLKS(10), .NUM_REFRESH(2), .ADDR_W(11)) dutB (
    .clk(clk), .rstN(rstN), .casLat(clB), .burstLen(blB), .burstType(btB), .driveSel(drB),
    .cke(ckeB), .csN(csB), .rasN(rasB), .casN(casB), .weN(weB), .addr(addrB), .ba(baB),
    .initDone(doneB), .cfgError(errB));

  function automatic bit clBad(logic [2:0] c);
    return !(c inside {3'd3, 3'd4, 3'd5});
  endfunction

  function automatic expEnt_t mk(bit c, bit [3:0] p, bit [10:0] a, bit [1:0] b, bit d, string r);
    expEnt_t e;
    e.cke = c; e.pins = p; e.addr = a; e.ba = b; e.done = d; e.req = r;
    return e;
  endfunction

  // Behavioural expected bus trace, one entry per clock after reset release.
  function automatic expQ_t buildExp(int s, int trp, int tmrd, int trfc, int lock, int nref,
                                     logic [2:0] cl, logic [2:0] bl, logic bt, logic [1:0] dr);
    expQ_t q;
    bit [10:0] mw, ext;
    bit [2:0] clUse;
    int m, f, doneAt;
    clUse = clBad(cl) ? 3'd3 : cl;
    mw  = (11'(clUse) << 4) | (11'(bt) << 3) | 11'(bl);
    ext = (11'(dr[1]) << 6) | (11'(dr[0]) << 1);
    for (int i = 0; i < s; i++) q.push_back(mk(0, 4'b0111, 0, 0, 0, "R1"));
    q.push_back(mk(1, 4'b0111, 0, 0, 0, "R2"));
    q.push_back(mk(1, 4'b0010, 11'h400, 0, 0, "R2"));
    for (int i = 1; i < trp; i++) q.push_back(mk(1, 4'b0111, 0, 0, 0, "R4"));
    q.push_back(mk(1, 4'b0000, ext, 2'b01, 0, "R5"));
    for (int i = 1; i < tmrd; i++) q.push_back(mk(1, 4'b0111, 0, 0, 0, "R4"));
    m = q.size();
    q.push_back(mk(1, 4'b0000, mw | 11'h100, 0, 0, "R6"));
    for (int i = 1; i < tmrd; i++) q.push_back(mk(1, 4'b0111, 0, 0, 0, "R4"));
    q.push_back(mk(1, 4'b0010, 11'h400, 0, 0, "R3"));
    for (int i = 1; i < trp; i++) q.push_back(mk(1, 4'b0111, 0, 0, 0, "R4"));
    for (int r = 0; r < nref; r++) begin
      q.push_back(mk(1, 4'b0001, 0, 0, 0, "R3"));
      for (int i = 1; i < trfc; i++) q.push_back(mk(1, 4'b0111, 0, 0, 0, "R4"));
    end
    f = q.size();
    q.push_back(mk(1, 4'b0000, mw, 0, 0, "R6"));
    doneAt = (f + tmrd > m + lock) ? f + tmrd : m + lock;
    while (q.size() < doneAt) q.push_back(mk(1, 4'b0111, 0, 0, 0, "R7"));
    return q;
  endfunction

  function automatic expEnt_t pick(expQ_t q, int i);
    if (i < q.size()) return q[i];
    return mk(1, 4'b0111, 0, 0, 1, "R7");
  endfunction

  task automatic cmpBus(string who, int cyc, expEnt_t e, logic c, logic [3:0] p,
                        logic [10:0] a, logic [1:0] b, logic d, logic ce, logic ceExp);
    tests++;
    if ({c, p, a, b, d} !== {e.cke, e.pins, e.addr, e.ba, e.done}) begin
      fails++;
      $display("FAIL %s %s cycle %0d: got cke=%b cmd=%b addr=%h ba=%b done=%b, expected cke=%b cmd=%b addr=%h ba=%b done=%b",
               e.req, who, cyc, c, p, a, b, d, e.cke, e.pins, e.addr, e.ba, e.done);
    end
    tests++;
    if (ce !== ceExp) begin
      fails++;
      $display("FAIL R8 %s cycle %0d: cfgError got %b expected %b", who, cyc, ce, ceExp);
    end
  endtask

  task automatic checkReset();
    @(negedge clk);
    cmpBus("dut reset", -1, mk(0, 4'b0111, 0, 0, 0, "R1"), ckeA, {csA, rasA, casA, weA},
           addrA, baA, doneA, errA, 1'b0);
    cmpBus("dutB reset", -1, mk(0, 4'b0111, 0, 0, 0, "R1"), ckeB, {csB, rasB, casB, weB},
           addrB, baB, doneB, errB, 1'b0);
  endtask

  task automatic runPass(int cycles, bit lateChange);
    expQ_t qA, qB;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    checkReset();
    qA = buildExp(20, 3, 2, 5, 200, 3, clA, blA, btA, drA);
    qB = buildExp(8, 2, 3, 4, 10, 2, clB, blB, btB, drB);
    rstN = 1'b1;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk);
      @(negedge clk);
      cmpBus("dut", i, pick(qA, i), ckeA, {csA, rasA, casA, weA}, addrA, baA, doneA,
             errA, clBad(clA));
      cmpBus("dutB", i, pick(qB, i), ckeB, {csB, rasB, casB, weB}, addrB, baB, doneB,
             errB, clBad(clB));
      if (lateChange && i == 240) begin
        // R7: after done, configuration changes must not reach the bus
        clA = 3'd4; blA = 3'd7; btA = 1'b0; drA = 2'b00;
        // R8: legal latency clears the error flag one clock later
        clB = 3'd4; blB = 3'd2; drB = 2'b11;
      end
    end
  endtask

  initial begin : watchdog
    #250000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    runPass(260, 1'b1);
    clA = 3'd4; blA = 3'd2; btA = 1'b0; drA = 2'b01;
    clB = 3'd0; blB = 3'd7; btB = 1'b1; drB = 2'b10;
    runPass(250, 1'b0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule